// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 64 interrupt lines into one request towards a processor. Each line is first brought into the clock domain, then handled as a level input or as an edge input that is latched. Each line has its own enable bit and a priority level. A tree arbiter selects the enabled pending line with the highest level, and the processor reads that line's number from a vector register. A single request output reports that a winner exists, and only while the global generate bit is set.

Software controls the block through a 32-bit register bus with byte addresses. Enables are changed only through write-one-to-set and write-one-to-clear words, so there is never a read-modify-write. Each line has its own configuration word, and the words sit 8 bytes apart. A vector read records the returned line as the claimed one. A later write to the end-of-interrupt word releases the latched edge of that line. One bit in the reset word returns every register to zero.

Register map (byte offsets): reset 0x000, generate enable 0x008, vector 0x010, end-of-interrupt 0x018, enable-set 0x020 (lines 0–31) and 0x028 (lines 32–63), enable-clear 0x040 and 0x048, line n configuration at 0x400 + 8·n.

Top module: `vic_top`

## Requirements
- R1: After the reset input, the request output is 0, the vector word reads 64, and both enable words read 0.
- R2: A write to enable-set 0x020 (lines 0–31) or 0x028 (lines 32–63) sets the enable of every line whose bit is 1 and leaves the others unchanged. Bit j of either word maps to line 32·bank + j. Reading either set address returns that bank's current enables.
- R3: A write to enable-clear 0x040 or 0x048 clears the enable of every line whose bit is 1 and leaves the others unchanged.
- R4: The configuration word of line n is at 0x400 + 8·n. Bits [3:0] hold the priority level and bit 8 holds the edge select (1 = edge). The word reads back as it was written.
- R5: A line with edge select 0 is pending exactly while its synchronized input is 1. An end-of-interrupt write does not affect it.
- R6: A line with edge select 1 becomes pending on a 0-to-1 transition of its synchronized input and stays pending after the input falls. It clears after a vector read that returns it followed by an end-of-interrupt write. A later rising edge makes it pending again.
- R7: The vector word returns the enabled pending line with the highest level. When levels tie, the lower line number wins.
- R8: With no enabled pending line, the vector word reads 64 (no valid interrupt).
- R9: The request output is 1 exactly when the generate bit (bit 0 of 0x008) is 1 and some enabled line is pending. The vector word does not depend on the generate bit.
- R10: Writing 1 to bit 0 of the reset word 0x000 clears all enables, all configuration words, the generate bit and every latched edge.
- R11: A disabled line is left out of the vector and the request, but its edge is still latched. The line becomes the winner as soon as it is enabled.
- R12: An end-of-interrupt write that follows no vector read since the last end-of-interrupt write leaves every latched edge in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (a read of the vector word claims the winner) |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| src_i | input | 64 | Interrupt source lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a pending edge line whose input has already dropped. From the ports it cannot be told apart from a level line that is still high, unless the input is lowered before the vector is read and the claim-and-release sequence then follows. The stimulus does this explicitly. It also releases a line with no claim in place, and it raises an edge while the line is disabled, so the latch state shows up in the vector only when the line is enabled again. The priority tie is reached by giving two lines far apart in the tree the same level, so the decision is made at the root node.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Width of one bus word and distance between neighbouring register slots.
  localparam int unsigned VIC_WORD_W = 32;
  localparam int unsigned VIC_SLOT_B = 8;

  // Byte offsets of the register words.
  localparam int unsigned OFS_RST = 'h000;
  localparam int unsigned OFS_GEN = 'h008;
  localparam int unsigned OFS_VEC = 'h010;
  localparam int unsigned OFS_EOI = 'h018;
  localparam int unsigned OFS_SET = 'h020;
  localparam int unsigned OFS_CLR = 'h040;
  localparam int unsigned OFS_CFG = 'h400;

  // Bit position of the edge select inside a configuration word.
  localparam int unsigned CFG_EDGE_BIT = 8;

  function automatic int unsigned vic_cfg_ofs(int unsigned n);
    return OFS_CFG + VIC_SLOT_B * n;
  endfunction

  function automatic int unsigned vic_bank_ofs(int unsigned base, int unsigned b);
    return base + VIC_SLOT_B * b;
  endfunction
endpackage

// File: rtl/vic_sync_edge.sv
module vic_sync_edge #(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] rise_o
);
  // One extra stage beyond the synchronizer holds the previous value.
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [NUM_SRC-1:0] sh_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < DEPTH; s++) sh_q[s] <= '0;
    end else begin
      sh_q[0] <= src_i;
      for (int s = 1; s < DEPTH; s++) sh_q[s] <= sh_q[s-1];
    end
  end

  assign lvl_o  = sh_q[SYNC_STAGES-1];
  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/vic_pending.sv
module vic_pending #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_clr_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [NUM_SRC-1:0] edge_cfg_i,
  input  logic [NUM_SRC-1:0] eoi_clr_i,
  output logic [NUM_SRC-1:0] edge_lat_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] lat_q;
  logic [NUM_SRC-1:0] lat_set;
  logic [NUM_SRC-1:0] lat_keep;

  // A new edge wins over a release in the same cycle.
  assign lat_set  = rise_i & edge_cfg_i;
  assign lat_keep = lat_q & ~eoi_clr_i & edge_cfg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lat_q <= '0;
    else if (soft_clr_i) lat_q <= '0;
    else                 lat_q <= lat_keep | lat_set;
  end

  assign edge_lat_o = lat_q;
  assign pend_o     = (edge_cfg_i & lat_q) | (~edge_cfg_i & lvl_i);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned ID_W    = $clog2(NUM_SRC) + 1
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  output logic                     win_vld_o,
  output logic [ID_W-1:0]          win_id_o
);
  // Heap-ordered tournament tree: node k has children 2k+1 and 2k+2, the
  // leaves start at NUM_SRC-1 (NUM_SRC a power of two).
  localparam int unsigned NODES = 2 * NUM_SRC - 1;

  logic             node_vld [NODES];
  logic [LVL_W-1:0] node_lvl [NODES];
  logic [ID_W-1:0]  node_id  [NODES];

  // Left child covers the lower source numbers, so it wins a tie.
  function automatic logic left_wins(logic lv, logic [LVL_W-1:0] ll,
                                     logic rv, logic [LVL_W-1:0] rl);
    return lv && (!rv || (ll >= rl));
  endfunction

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    assign node_vld[NUM_SRC-1+i] = req_i[i];
    assign node_lvl[NUM_SRC-1+i] = lvl_i[i*LVL_W +: LVL_W];
    assign node_id[NUM_SRC-1+i]  = ID_W'(i);
  end

  for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_node
    logic pick_l;
    assign pick_l      = left_wins(node_vld[2*k+1], node_lvl[2*k+1],
                                   node_vld[2*k+2], node_lvl[2*k+2]);
    assign node_vld[k] = node_vld[2*k+1] | node_vld[2*k+2];
    assign node_lvl[k] = pick_l ? node_lvl[2*k+1] : node_lvl[2*k+2];
    assign node_id[k]  = pick_l ? node_id[2*k+1]  : node_id[2*k+2];
  end

  assign win_vld_o = node_vld[0];
  assign win_id_o  = node_vld[0] ? node_id[0] : ID_W'(NUM_SRC);
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned LVL_W   = 4,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned ID_W    = $clog2(NUM_SRC) + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     re_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [VIC_WORD_W-1:0]    wdata_i,
  output logic [VIC_WORD_W-1:0]    rdata_o,
  input  logic                     win_vld_i,
  input  logic [ID_W-1:0]          win_id_i,
  output logic [NUM_SRC-1:0]       en_o,
  output logic [NUM_SRC-1:0]       edge_cfg_o,
  output logic [NUM_SRC*LVL_W-1:0] lvl_cfg_o,
  output logic                     gen_en_o,
  output logic                     soft_clr_o,
  output logic [NUM_SRC-1:0]       eoi_clr_o
);
  localparam int unsigned BANKS = (NUM_SRC + VIC_WORD_W - 1) / VIC_WORD_W;
  localparam int unsigned SEL_W = $clog2(NUM_SRC);

  logic [BANKS-1:0]            set_hit, clr_hit;
  logic [NUM_SRC-1:0]          cfg_hit, set_mask, clr_mask;
  logic                        rst_hit, gen_hit, vec_hit, eoi_hit;
  logic                        eoi_wr, vec_rd;
  logic [NUM_SRC-1:0]          en_q, cfg_edge_q;
  logic [NUM_SRC*LVL_W-1:0]    cfg_lvl_q;
  logic                        gen_q;
  logic                        claim_vld_q;
  logic [SEL_W-1:0]            claim_id_q;
  logic [BANKS*VIC_WORD_W-1:0] en_pad;

  // ---------------- address decode ----------------
  assign rst_hit = (addr_i == ADDR_W'(OFS_RST));
  assign gen_hit = (addr_i == ADDR_W'(OFS_GEN));
  assign vec_hit = (addr_i == ADDR_W'(OFS_VEC));
  assign eoi_hit = (addr_i == ADDR_W'(OFS_EOI));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign set_hit[b] = (addr_i == ADDR_W'(vic_bank_ofs(OFS_SET, b)));
    assign clr_hit[b] = (addr_i == ADDR_W'(vic_bank_ofs(OFS_CLR, b)));
    for (genvar j = 0; j < VIC_WORD_W; j++) begin : g_bit
      if (b * VIC_WORD_W + j < NUM_SRC) begin : g_live
        assign set_mask[b*VIC_WORD_W+j] = we_i & set_hit[b] & wdata_i[j];
        assign clr_mask[b*VIC_WORD_W+j] = we_i & clr_hit[b] & wdata_i[j];
      end
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
    assign cfg_hit[n]   = (addr_i == ADDR_W'(vic_cfg_ofs(n)));
    assign eoi_clr_o[n] = eoi_wr & claim_vld_q & (claim_id_q == SEL_W'(n));
  end

  assign soft_clr_o = we_i & rst_hit & wdata_i[0];
  assign eoi_wr     = we_i & eoi_hit;
  assign vec_rd     = re_i & vec_hit;

  // ---------------- enables ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= '0;
    else if (soft_clr_o) en_q <= '0;
    else                 en_q <= (en_q | set_mask) & ~clr_mask;
  end

  // ---------------- per-source configuration ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_edge_q <= '0;
      cfg_lvl_q  <= '0;
    end else if (soft_clr_o) begin
      cfg_edge_q <= '0;
      cfg_lvl_q  <= '0;
    end else begin
      for (int n = 0; n < NUM_SRC; n++) begin
        if (we_i && cfg_hit[n]) begin
          cfg_edge_q[n]                <= wdata_i[CFG_EDGE_BIT];
          cfg_lvl_q[n*LVL_W +: LVL_W]  <= wdata_i[LVL_W-1:0];
        end
      end
    end
  end

  // ---------------- generate enable ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gen_q <= 1'b0;
    else if (soft_clr_o)      gen_q <= 1'b0;
    else if (we_i && gen_hit) gen_q <= wdata_i[0];
  end

  // ---------------- claim of the returned vector ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_vld_q <= 1'b0;
      claim_id_q  <= '0;
    end else if (soft_clr_o || eoi_wr) begin
      claim_vld_q <= 1'b0;
    end else if (vec_rd) begin
      claim_vld_q <= win_vld_i;
      claim_id_q  <= win_id_i[SEL_W-1:0];
    end
  end

  // ---------------- read mux ----------------
  assign en_pad = (BANKS*VIC_WORD_W)'(en_q);

  always_comb begin
    rdata_o = '0;
    if (gen_hit) rdata_o[0] = gen_q;
    if (vec_hit) rdata_o = VIC_WORD_W'(win_id_i);
    for (int b = 0; b < BANKS; b++) begin
      if (set_hit[b] || clr_hit[b]) rdata_o = en_pad[b*VIC_WORD_W +: VIC_WORD_W];
    end
    for (int n = 0; n < NUM_SRC; n++) begin
      if (cfg_hit[n]) begin
        rdata_o                 = '0;
        rdata_o[CFG_EDGE_BIT]   = cfg_edge_q[n];
        rdata_o[LVL_W-1:0]      = cfg_lvl_q[n*LVL_W +: LVL_W];
      end
    end
  end

  assign en_o       = en_q;
  assign edge_cfg_o = cfg_edge_q;
  assign lvl_cfg_o  = cfg_lvl_q;
  assign gen_en_o   = gen_q;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 64,
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic                  bus_re_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [VIC_WORD_W-1:0] bus_wdata_i,
  output logic [VIC_WORD_W-1:0] bus_rdata_o,
  input  logic [NUM_SRC-1:0]    src_i,
  output logic                  irq_o
);
  localparam int unsigned ID_W = $clog2(NUM_SRC) + 1;

  // Named internal events, also observed by the bound checker.
  logic [NUM_SRC-1:0]       lvl_sync, rise;
  logic [NUM_SRC-1:0]       en_q, edge_cfg, eoi_clr, edge_lat, pend, req;
  logic [NUM_SRC*LVL_W-1:0] lvl_cfg;
  logic                     gen_en, soft_clr, win_vld;
  logic [ID_W-1:0]          win_id;

  vic_sync_edge #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .lvl_o  (lvl_sync),
    .rise_o (rise)
  );

  vic_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr),
    .rise_i     (rise),
    .lvl_i      (lvl_sync),
    .edge_cfg_i (edge_cfg),
    .eoi_clr_i  (eoi_clr),
    .edge_lat_o (edge_lat),
    .pend_o     (pend)
  );

  assign req = pend & en_q;

  vic_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
    .req_i     (req),
    .lvl_i     (lvl_cfg),
    .win_vld_o (win_vld),
    .win_id_o  (win_id)
  );

  vic_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (bus_we_i),
    .re_i       (bus_re_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .win_vld_i  (win_vld),
    .win_id_i   (win_id),
    .en_o       (en_q),
    .edge_cfg_o (edge_cfg),
    .lvl_cfg_o  (lvl_cfg),
    .gen_en_o   (gen_en),
    .soft_clr_o (soft_clr),
    .eoi_clr_o  (eoi_clr)
  );

  assign irq_o = gen_en & win_vld;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned ID_W    = $clog2(NUM_SRC) + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_we_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [VIC_WORD_W-1:0] bus_wdata_i,
  input logic                  irq_o,
  input logic                  gen_en,
  input logic [NUM_SRC-1:0]    en_q,
  input logic [NUM_SRC-1:0]    req,
  input logic [NUM_SRC-1:0]    edge_lat,
  input logic                  win_vld,
  input logic [ID_W-1:0]       win_id
);
  localparam int unsigned SEL_W = $clog2(NUM_SRC);

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gen_en); // R9

  AST_IRQ_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_en && (req != '0)) |-> irq_o); // R9

  AST_WIN_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |-> req[win_id[SEL_W-1:0]]); // R7

  AST_IDLE_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req == '0) |-> (win_id == ID_W'(NUM_SRC))); // R8

  AST_SET_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_SET))
      |=> ((en_q[VIC_WORD_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i))); // R2

  AST_CLR_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_CLR))
      |=> ((en_q[VIC_WORD_W-1:0] & $past(bus_wdata_i)) == '0)); // R3

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_W'(OFS_RST) && bus_wdata_i[0])
      |=> (en_q == '0 && !gen_en && edge_lat == '0)); // R10
endmodule

bind vic_top vic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .gen_en      (gen_en),
  .en_q        (en_q),
  .req         (req),
  .edge_lat    (edge_lat),
  .win_vld     (win_vld),
  .win_id      (win_id)
);

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
  localparam int unsigned N  = 64;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] A_RST  = 12'h000;
  localparam logic [AW-1:0] A_GEN  = 12'h008;
  localparam logic [AW-1:0] A_VEC  = 12'h010;
  localparam logic [AW-1:0] A_EOI  = 12'h018;
  localparam logic [AW-1:0] A_SET0 = 12'h020;
  localparam logic [AW-1:0] A_SET1 = 12'h028;
  localparam logic [AW-1:0] A_CLR0 = 12'h040;
  localparam logic [AW-1:0] A_CLR1 = 12'h048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0, re = 1'b0, probe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  src = '0;
  logic          irq;

  always #10 clk = ~clk;  // 50 MHz

  vic_top #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_re_i    (re),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .src_i       (src),
    .irq_o       (irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       cur;
  logic [31:0] act;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic logic [AW-1:0] cfg_a(int n);
    return AW'(12'h400 + n * 8);
  endfunction

  // ---------------- driver ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk); re = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    @(negedge clk); probe = 1'b1;
    sb_q.push_back('{1'b1, {31'b0, e}, tag});
    @(negedge clk); probe = 1'b0;
  endtask

  task automatic drive_src(input int i, input logic v);
    @(negedge clk); src[i] = v;
    repeat (5) @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    #5;
    if ((re || probe) && sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      act = cur.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (act !== cur.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rd_chk(A_VEC, 32'd64, "R1 vector after reset");
    irq_chk(1'b0, "R1 request after reset");
    rd_chk(A_SET0, 32'h0, "R1 enables low after reset");
    rd_chk(A_SET1, 32'h0, "R1 enables high after reset");

    wr(A_SET0, 32'h0000_0005);
    rd_chk(A_SET0, 32'h0000_0005, "R2 set low");
    wr(A_SET0, 32'h0000_0010);
    rd_chk(A_SET0, 32'h0000_0015, "R2 zero bits keep enables");
    wr(A_SET1, 32'h8000_0001);
    rd_chk(A_SET1, 32'h8000_0001, "R2 set high");

    wr(A_CLR0, 32'h0000_0004);
    rd_chk(A_SET0, 32'h0000_0011, "R3 clear low");
    wr(A_CLR1, 32'h0000_0001);
    rd_chk(A_SET1, 32'h8000_0000, "R3 clear high");

    wr(cfg_a(4), 32'h0000_0003);
    rd_chk(cfg_a(4), 32'h0000_0003, "R4 config level line 4");
    wr(cfg_a(63), 32'h0000_0105);
    rd_chk(cfg_a(63), 32'h0000_0105, "R4 config edge line 63");
    wr(A_GEN, 32'h1);

    // level behaviour
    drive_src(4, 1'b1);
    rd_chk(A_VEC, 32'd4, "R5 level line pending");
    irq_chk(1'b1, "R9 request with enabled pending");
    wr(A_EOI, 32'h0);
    rd_chk(A_VEC, 32'd4, "R5 release leaves level line");
    wr(A_GEN, 32'h0);
    irq_chk(1'b0, "R9 request gated by generate bit");
    rd_chk(A_VEC, 32'd4, "R9 vector independent of generate");
    wr(A_GEN, 32'h1);
    irq_chk(1'b1, "R9 request back on");
    drive_src(4, 1'b0);
    rd_chk(A_VEC, 32'd64, "R5 level line drops");
    irq_chk(1'b0, "R8 no request when idle");

    // edge behaviour
    drive_src(63, 1'b1);
    drive_src(63, 1'b0);
    wr(A_EOI, 32'h0);
    rd_chk(A_VEC, 32'd63, "R12 release without claim keeps edge");
    wr(A_EOI, 32'h0);
    rd_chk(A_VEC, 32'd64, "R6 claimed edge released");
    drive_src(63, 1'b1);
    rd_chk(A_VEC, 32'd63, "R6 new edge latched again");

    // priority
    drive_src(4, 1'b1);
    rd_chk(A_VEC, 32'd63, "R7 higher level wins");
    wr(cfg_a(0), 32'h0000_0005);
    drive_src(0, 1'b1);
    rd_chk(A_VEC, 32'd0, "R7 tie goes to lower number");
    drive_src(0, 1'b0);
    rd_chk(A_VEC, 32'd63, "R7 edge line after tie removed");
    wr(A_EOI, 32'h0);
    rd_chk(A_VEC, 32'd4, "R6 release exposes level line");
    drive_src(4, 1'b0);
    rd_chk(A_VEC, 32'd64, "R8 nothing pending");

    // disabled edge still latched
    wr(A_CLR1, 32'h8000_0000);
    drive_src(63, 1'b0);
    drive_src(63, 1'b1);
    rd_chk(A_VEC, 32'd64, "R11 disabled line ignored");
    irq_chk(1'b0, "R11 no request for disabled line");
    wr(A_SET1, 32'h8000_0000);
    rd_chk(A_VEC, 32'd63, "R11 latched edge seen on enable");
    irq_chk(1'b1, "R11 request on enable");

    // soft reset
    wr(A_RST, 32'h1);
    rd_chk(A_SET0, 32'h0, "R10 enables low cleared");
    rd_chk(A_SET1, 32'h0, "R10 enables high cleared");
    rd_chk(cfg_a(63), 32'h0, "R10 config cleared");
    rd_chk(A_GEN, 32'h0, "R10 generate cleared");
    rd_chk(A_VEC, 32'd64, "R10 vector idle");
    irq_chk(1'b0, "R10 request low");
    wr(A_SET1, 32'h8000_0000);
    drive_src(63, 1'b0);
    rd_chk(A_VEC, 32'd64, "R10 edge latch cleared, line now level");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule